// File: doc/BRIEF.md
# NAND command and address sequencer

This block drives the control and byte lanes of a raw NAND flash device to issue one complete command. A request gives an opcode, an optional column address, an optional page address, a flag for devices above 128 MiB and a flag for a 16-bit data bus. The block then produces the bus activity in order: a command latch, then any address latches, then a turnaround cycle, then whatever the opcode needs next.

Each latch cycle holds the write strobe low for a programmable number of clocks. The byte and the latch-enable lines are held steady through the rising edge of the strobe. After the address phase the block does one of four things, chosen by the opcode. Erase and program opcodes finish at once. A page read adds a read-confirm command and then waits a programmable delay. A device reset waits the delay, issues a status command and then hands over to an external status-poll block through a request/acknowledge pair. Any other opcode waits the delay and then finishes.

The caller starts a request with a one-cycle start pulse while the block is idle. It watches busy, and gets a one-cycle done pulse when the request is complete. Data transfer, error correction and bad-block handling belong to other blocks.

Top module: `nand_cmd_seq`

## Requirements
- R1: While idle (and after reset) busy=0, nand_ce_n=1, nand_we_n=1, nand_cle=0 and nand_ale=0. A start pulse is accepted only while idle; start while busy has no effect on the bytes emitted.
- R2: Every request begins with a latch of op_code with nand_cle=1, nand_ale=0 and nand_ce_n=0. In every latch nand_we_n is low for max(we_low_clks,1) consecutive clocks, and the byte is captured on the rising edge of nand_we_n.
- R3: With col_vld=1, two latches with nand_ale=1 and nand_cle=0 follow the command: column bits 7:0 first, then bits 15:8.
- R4: With bus_wide=1, the column value is shifted right by one bit before it is split into bytes.
- R5: With row_vld=1, the page address follows any column bytes as latches with nand_ale=1: bits 7:0 first, then bits 15:8.
- R6: A third page latch carrying bits 23:16 is sent only when cap_big=1.
- R7: With col_vld=0 and row_vld=0, no address latch is emitted.
- R8: In the clock after the rising strobe edge of the last latch of the command/address phase, nand_cle=0 and nand_ale=0 while nand_ce_n=0.
- R9: For opcodes 0x60, 0xD0, 0x80 and 0x10, done pulses exactly 2 clocks after the rising strobe edge of the last latch, with no delay.
- R10: For opcode 0x00, a command latch of 0x30 follows the address phase. done pulses wait_clks+2 clocks after its rising strobe edge.
- R11: For opcode 0xFF, a command latch of 0x70 has its rising strobe edge wait_clks+max(we_low_clks,1)+4 clocks after that of the reset command. poll_req then stays high until poll_ack, and done pulses in the clock after poll_ack is seen.
- R12: done is high for exactly one clock, and busy is low in the clock after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle request strobe, sampled while idle |
| op_code | input | 8 | Command opcode |
| col_vld | input | 1 | Column address present |
| col_addr | input | 16 | Column address |
| row_vld | input | 1 | Page address present |
| row_addr | input | 24 | Page address |
| cap_big | input | 1 | Device larger than 128 MiB: send third page byte |
| bus_wide | input | 1 | 16-bit data bus: halve the column value |
| we_low_clks | input | WE_W | Strobe low time in clocks (0 treated as 1) |
| wait_clks | input | DLY_W | Programmable post-command delay in clocks |
| poll_ack | input | 1 | Status-poll block reports device ready |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| poll_req | output | 1 | Request to status-poll block after reset |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_io | output | 8 | Byte lane |

## Verification
The bench uses the default widths: a 4-bit strobe-time field and a 16-bit delay field. Only small run-time values are driven on them: strobe times of 0, 1, 2 and 3 and delays from 0 to 7 clocks. These values bring the zero-means-one strobe rule and the zero-delay path of the wait timer within reach. Short delays also keep the exact clock counts of R9, R10 and R11 checkable on every opcode class within a short run. The vectors cover every combination of column, page, cap_big and bus_wide that changes the address byte count or the byte values.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  localparam int IO_W      = 8;
  localparam int COL_W     = 16;
  localparam int ROW_W     = 24;
  localparam int COL_BYTES = COL_W / IO_W;
  localparam int ROW_BYTES = ROW_W / IO_W;
  localparam int MAX_ITEMS = 1 + COL_BYTES + ROW_BYTES;
  localparam int CNT_W     = $clog2(MAX_ITEMS + 1);

  localparam logic [IO_W-1:0] OP_READ0    = 8'h00;
  localparam logic [IO_W-1:0] OP_READCONF = 8'h30;
  localparam logic [IO_W-1:0] OP_STATUS   = 8'h70;
  localparam logic [IO_W-1:0] OP_RESET    = 8'hFF;
  localparam logic [IO_W-1:0] OP_ERASE1   = 8'h60;
  localparam logic [IO_W-1:0] OP_ERASE2   = 8'hD0;
  localparam logic [IO_W-1:0] OP_SEQIN    = 8'h80;
  localparam logic [IO_W-1:0] OP_PROG     = 8'h10;

  typedef struct packed {
    logic [IO_W-1:0] data;
    logic            is_cmd;
  } latch_item_t;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_ADDR, SQ_GAP, SQ_CONF, SQ_WAIT, SQ_STAT, SQ_POLL, SQ_FIN
  } seq_state_t;

  typedef enum logic [1:0] {
    LE_IDLE, LE_LOW, LE_HIGH
  } latch_state_t;

endpackage

// File: rtl/nand_addr_plan.sv
module nand_addr_plan
  import nand_seq_pkg::*;
(
  input  logic [IO_W-1:0]  op,
  input  logic             col_vld,
  input  logic [COL_W-1:0] col,
  input  logic             row_vld,
  input  logic [ROW_W-1:0] row,
  input  logic             big,
  input  logic             wide,
  output latch_item_t      items [MAX_ITEMS],
  output logic [CNT_W-1:0] count
);

  logic [COL_W-1:0] col_eff;
  logic [CNT_W-1:0] n;

  assign col_eff = wide ? (col >> 1) : col;

  always_comb begin
    for (int i = 0; i < MAX_ITEMS; i++) items[i] = '0;
    items[0] = '{data: op, is_cmd: 1'b1};
    n = CNT_W'(1);
    if (col_vld) begin
      for (int b = 0; b < COL_BYTES; b++) begin
        items[n] = '{data: col_eff[b*IO_W +: IO_W], is_cmd: 1'b0};
        n = n + CNT_W'(1);
      end
    end
    if (row_vld) begin
      for (int b = 0; b < ROW_BYTES; b++) begin
        if ((b < ROW_BYTES - 1) || big) begin
          items[n] = '{data: row[b*IO_W +: IO_W], is_cmd: 1'b0};
          n = n + CNT_W'(1);
        end
      end
    end
    count = n;
  end

endmodule

// File: rtl/nand_latch_engine.sv
module nand_latch_engine
  import nand_seq_pkg::*;
#(
  parameter int WE_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  latch_item_t     item,
  input  logic [WE_W-1:0] low_clks,
  output logic            ready,
  output logic            fin,
  output logic            we_n,
  output logic            cle,
  output logic            ale,
  output logic [IO_W-1:0] io
);

  latch_state_t    st_q, st_d;
  logic [WE_W-1:0] cnt_q, cnt_d;
  logic            we_n_d, cle_d, ale_d;
  logic [IO_W-1:0] io_d;

  assign ready = (st_q != LE_LOW);
  assign fin   = (st_q == LE_HIGH);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    we_n_d = we_n;
    cle_d  = cle;
    ale_d  = ale;
    io_d   = io;
    case (st_q)
      LE_LOW: begin
        if (cnt_q == '0) begin
          we_n_d = 1'b1;
          st_d   = LE_HIGH;
        end else begin
          cnt_d = cnt_q - WE_W'(1);
        end
      end
      default: begin
        if (go) begin
          io_d   = item.data;
          cle_d  = item.is_cmd;
          ale_d  = ~item.is_cmd;
          we_n_d = 1'b0;
          cnt_d  = (low_clks == '0) ? '0 : low_clks - WE_W'(1);
          st_d   = LE_LOW;
        end else begin
          io_d   = '0;
          cle_d  = 1'b0;
          ale_d  = 1'b0;
          we_n_d = 1'b1;
          st_d   = LE_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= LE_IDLE;
      cnt_q <= '0;
      we_n  <= 1'b1;
      cle   <= 1'b0;
      ale   <= 1'b0;
      io    <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      we_n  <= we_n_d;
      cle   <= cle_d;
      ale   <= ale_d;
      io    <= io_d;
    end
  end

endmodule

// File: rtl/nand_delay_timer.sv
module nand_delay_timer #(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DLY_W-1:0] value,
  output logic             zero
);

  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign zero   = (cnt_q == '0);
  assign cnt_en = load | ~zero;

  always_comb begin
    cnt_d = cnt_q;
    if (load) cnt_d = value;
    else if (!zero) cnt_d = cnt_q - DLY_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nand_seq_pkg::*;
#(
  parameter int WE_W  = 4,
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       op_code,
  input  logic             col_vld,
  input  logic [15:0]      col_addr,
  input  logic             row_vld,
  input  logic [23:0]      row_addr,
  input  logic             cap_big,
  input  logic             bus_wide,
  input  logic [WE_W-1:0]  we_low_clks,
  input  logic [DLY_W-1:0] wait_clks,
  input  logic             poll_ack,
  output logic             busy,
  output logic             done,
  output logic             poll_req,
  output logic             nand_ce_n,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_we_n,
  output logic [7:0]       nand_io
);

  // reset: asserted at once, released through two flops
  logic rst_s1, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  seq_state_t       st_q, st_d;
  logic [IO_W-1:0]  op_q;
  logic             cv_q, rv_q, big_q, wide_q;
  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic             sent_q, sent_d;
  logic             cap_en;

  latch_item_t      plan_items [MAX_ITEMS];
  logic [CNT_W-1:0] plan_cnt;
  logic             eng_go, eng_ready, eng_fin;
  latch_item_t      eng_item;
  logic             tmr_load, tmr_zero;
  logic             quick_op;

  nand_addr_plan u_plan (
    .op      (op_q),
    .col_vld (cv_q),
    .col     (col_q),
    .row_vld (rv_q),
    .row     (row_q),
    .big     (big_q),
    .wide    (wide_q),
    .items   (plan_items),
    .count   (plan_cnt)
  );

  nand_latch_engine #(.WE_W(WE_W)) u_eng (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .go       (eng_go),
    .item     (eng_item),
    .low_clks (we_low_clks),
    .ready    (eng_ready),
    .fin      (eng_fin),
    .we_n     (nand_we_n),
    .cle      (nand_cle),
    .ale      (nand_ale),
    .io       (nand_io)
  );

  nand_delay_timer #(.DLY_W(DLY_W)) u_tmr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .load  (tmr_load),
    .value (wait_clks),
    .zero  (tmr_zero)
  );

  assign quick_op = (op_q == OP_ERASE1) || (op_q == OP_ERASE2) ||
                    (op_q == OP_SEQIN)  || (op_q == OP_PROG);

  always_comb begin
    st_d     = st_q;
    idx_d    = idx_q;
    eng_go   = 1'b0;
    eng_item = plan_items[idx_q];
    cap_en   = 1'b0;
    case (st_q)
      SQ_IDLE: begin
        if (start) begin
          cap_en = 1'b1;
          idx_d  = '0;
          st_d   = SQ_ADDR;
        end
      end
      SQ_ADDR: begin
        if ((idx_q < plan_cnt) && eng_ready) begin
          eng_go = 1'b1;
          idx_d  = idx_q + CNT_W'(1);
        end else if ((idx_q == plan_cnt) && eng_fin) begin
          st_d = SQ_GAP;
        end
      end
      SQ_GAP: begin
        if (quick_op)               st_d = SQ_FIN;
        else if (op_q == OP_READ0)  st_d = SQ_CONF;
        else                        st_d = SQ_WAIT;
      end
      SQ_CONF: begin
        eng_item = '{data: OP_READCONF, is_cmd: 1'b1};
        if (!sent_q && eng_ready) eng_go = 1'b1;
        else if (sent_q && eng_fin) st_d = SQ_WAIT;
      end
      SQ_WAIT: begin
        if (tmr_zero) st_d = (op_q == OP_RESET) ? SQ_STAT : SQ_FIN;
      end
      SQ_STAT: begin
        eng_item = '{data: OP_STATUS, is_cmd: 1'b1};
        if (!sent_q && eng_ready) eng_go = 1'b1;
        else if (sent_q && eng_fin) st_d = SQ_POLL;
      end
      SQ_POLL: begin
        if (poll_ack) st_d = SQ_FIN;
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  assign sent_d   = (st_d != st_q) ? 1'b0 : (sent_q | eng_go);
  assign tmr_load = (st_d == SQ_WAIT) && (st_q != SQ_WAIT);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q   <= SQ_IDLE;
      idx_q  <= '0;
      sent_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      sent_q <= sent_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      op_q   <= '0;
      cv_q   <= 1'b0;
      rv_q   <= 1'b0;
      big_q  <= 1'b0;
      wide_q <= 1'b0;
      col_q  <= '0;
      row_q  <= '0;
    end else if (cap_en) begin
      op_q   <= op_code;
      cv_q   <= col_vld;
      rv_q   <= row_vld;
      big_q  <= cap_big;
      wide_q <= bus_wide;
      col_q  <= col_addr;
      row_q  <= row_addr;
    end
  end

  assign busy      = (st_q != SQ_IDLE);
  assign done      = (st_q == SQ_FIN);
  assign poll_req  = (st_q == SQ_POLL);
  assign nand_ce_n = ~busy;

endmodule

// File: rtl/nand_cmd_seq_chk.sv
module nand_cmd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       poll_req,
  input logic       poll_ack,
  input logic       nand_ce_n,
  input logic       nand_cle,
  input logic       nand_ale,
  input logic       nand_we_n,
  input logic [7:0] nand_io
);

  // R2: byte and latch enables held steady into the rising strobe edge
  p_latch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nand_we_n) |-> ($stable(nand_io) && $stable(nand_cle) && $stable(nand_ale)));

  // R2: a strobe is only driven with chip enabled and exactly one latch enable
  p_strobe_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> (!nand_ce_n && $countones({nand_cle, nand_ale}) == 1));

  // R1: idle bus is quiet
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (nand_we_n && !nand_cle && !nand_ale));

  // R12: done lasts one clock and busy drops after it
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R11: poll request is held until acknowledged, bus quiet meanwhile
  p_poll_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_req && !poll_ack) |=> poll_req);

  p_poll_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    poll_req |-> (nand_we_n && !nand_cle && !nand_ale && !nand_ce_n));

endmodule

bind nand_cmd_seq nand_cmd_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .poll_req  (poll_req),
  .poll_ack  (poll_ack),
  .nand_ce_n (nand_ce_n),
  .nand_cle  (nand_cle),
  .nand_ale  (nand_ale),
  .nand_we_n (nand_we_n),
  .nand_io   (nand_io)
);

// File: tb/nand_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module nand_cmd_seq_tb_top;

  localparam int WE_W  = 4;
  localparam int DLY_W = 16;
  localparam int NVEC  = 9;

  typedef struct packed {
    logic [7:0]  op;
    logic        cv;
    logic [15:0] col;
    logic        pv;
    logic [23:0] pg;
    logic        big;
    logic        wide;
    logic [3:0]  w;
    logic [7:0]  d;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{8'h00, 1'b1, 16'h1234, 1'b1, 24'h056789, 1'b1, 1'b0, 4'd2, 8'd5},
    '{8'h00, 1'b1, 16'h0246, 1'b1, 24'hABCDEF, 1'b0, 1'b1, 4'd1, 8'd0},
    '{8'h80, 1'b1, 16'h0800, 1'b1, 24'h000040, 1'b1, 1'b0, 4'd3, 8'd4},
    '{8'h10, 1'b0, 16'h0000, 1'b0, 24'h000000, 1'b0, 1'b0, 4'd2, 8'd6},
    '{8'h60, 1'b0, 16'h0000, 1'b1, 24'h123456, 1'b1, 1'b0, 4'd1, 8'd3},
    '{8'hD0, 1'b0, 16'hFFFF, 1'b0, 24'hFFFFFF, 1'b1, 1'b1, 4'd2, 8'd2},
    '{8'hFF, 1'b0, 16'h0000, 1'b0, 24'h000000, 1'b0, 1'b0, 4'd2, 8'd3},
    '{8'h00, 1'b1, 16'h00A5, 1'b0, 24'h000000, 1'b0, 1'b0, 4'd0, 8'd7},
    '{8'h60, 1'b0, 16'h0000, 1'b1, 24'h9A7B3C, 1'b0, 1'b0, 4'd3, 8'd1}
  };

  logic clk, rst_n, start;
  logic [7:0] op_code;
  logic col_vld, row_vld, cap_big, bus_wide, poll_ack;
  logic [15:0] col_addr;
  logic [23:0] row_addr;
  logic [WE_W-1:0] we_low_clks;
  logic [DLY_W-1:0] wait_clks;
  logic busy, done, poll_req, nand_ce_n, nand_cle, nand_ale, nand_we_n;
  logic [7:0] nand_io;

  int tests, fails;

  nand_cmd_seq #(.WE_W(WE_W), .DLY_W(DLY_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code),
    .col_vld(col_vld), .col_addr(col_addr), .row_vld(row_vld),
    .row_addr(row_addr), .cap_big(cap_big), .bus_wide(bus_wide),
    .we_low_clks(we_low_clks), .wait_clks(wait_clks), .poll_ack(poll_ack),
    .busy(busy), .done(done), .poll_req(poll_req), .nand_ce_n(nand_ce_n),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_io(nand_io)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // expected latch list built from the requirements
  logic [7:0] exp_b [8];
  logic       exp_c [8];
  int         exp_n, exp_main;

  task automatic build_exp(input vec_t v);
    logic [15:0] c;
    exp_n = 0;
    exp_b[exp_n] = v.op; exp_c[exp_n] = 1'b1; exp_n++;          // R2
    c = v.wide ? (v.col >> 1) : v.col;                          // R4
    if (v.cv) begin                                             // R3
      exp_b[exp_n] = c[7:0];  exp_c[exp_n] = 1'b0; exp_n++;
      exp_b[exp_n] = c[15:8]; exp_c[exp_n] = 1'b0; exp_n++;
    end
    if (v.pv) begin                                             // R5
      exp_b[exp_n] = v.pg[7:0];  exp_c[exp_n] = 1'b0; exp_n++;
      exp_b[exp_n] = v.pg[15:8]; exp_c[exp_n] = 1'b0; exp_n++;
      if (v.big) begin                                          // R6
        exp_b[exp_n] = v.pg[23:16]; exp_c[exp_n] = 1'b0; exp_n++;
      end
    end
    exp_main = exp_n;
    if (v.op == 8'h00) begin exp_b[exp_n] = 8'h30; exp_c[exp_n] = 1'b1; exp_n++; end // R10
    if (v.op == 8'hFF) begin exp_b[exp_n] = 8'h70; exp_c[exp_n] = 1'b1; exp_n++; end // R11
  endtask

  logic [7:0] rec_b [8];
  logic       rec_c [8];
  logic       rec_a [8];
  int         rec_t [8];
  int         rec_n;

  task automatic run_vec(input vec_t v, input bit poke_busy);
    int k, lowrun, wl, done_k, ack_k, pollcnt;
    logic prev_we;
    build_exp(v);
    wl = (v.w == 0) ? 1 : int'(v.w);
    rec_n = 0; k = 0; lowrun = 0; done_k = -1; ack_k = -1; pollcnt = 0;
    @(negedge clk);
    op_code = v.op; col_vld = v.cv; col_addr = v.col; row_vld = v.pv;
    row_addr = v.pg; cap_big = v.big; bus_wide = v.wide;
    we_low_clks = v.w; wait_clks = 16'(v.d); start = 1'b1;
    prev_we = nand_we_n;
    @(negedge clk); start = 1'b0;
    while (k < 3000 && done_k < 0) begin
      k++;
      if (poke_busy && k >= 3 && k < 6) begin
        start = 1'b1; op_code = 8'hFF; col_vld = 1'b0; row_vld = 1'b0;
      end else start = 1'b0;
      if (!nand_we_n) lowrun++;
      if (nand_we_n && !prev_we) begin
        check(lowrun == wl, "R2", "strobe low width", lowrun, wl);
        if (rec_n < 8) begin
          rec_b[rec_n] = nand_io; rec_c[rec_n] = nand_cle;
          rec_a[rec_n] = nand_ale; rec_t[rec_n] = k;
        end
        rec_n++;
        lowrun = 0;
      end
      if (rec_n == exp_main && exp_main > 0 && k == rec_t[exp_main-1] + 1)
        check(!nand_cle && !nand_ale && !nand_ce_n, "R8", "turnaround lines",
              {nand_ce_n, nand_cle, nand_ale}, 0);
      poll_ack = 1'b0;
      if (poll_req) begin
        pollcnt++;
        if (pollcnt == 3) begin poll_ack = 1'b1; ack_k = k; end
      end
      if (done) done_k = k;
      prev_we = nand_we_n;
      if (done_k < 0) @(negedge clk);
    end
    poll_ack = 1'b0;
    check(done_k >= 0, "R12", "done seen", done_k, 1);
    check(rec_n == exp_n, v.cv ? "R3" : "R7", "latch count", rec_n, exp_n);
    for (int i = 0; i < exp_n && i < rec_n && i < 8; i++) begin
      check(rec_b[i] == exp_b[i],
            (i == 0) ? "R2" : (v.wide ? "R4" : (v.pv ? "R5" : "R3")),
            "latched byte", rec_b[i], exp_b[i]);
      check(rec_c[i] == exp_c[i] && rec_a[i] == !exp_c[i],
            (i < exp_main && v.big && v.pv) ? "R6" : "R2",
            "latch enables", {rec_c[i], rec_a[i]}, {exp_c[i], !exp_c[i]});
    end
    if (rec_n == exp_n && done_k >= 0) begin
      if (v.op == 8'h60 || v.op == 8'hD0 || v.op == 8'h80 || v.op == 8'h10)
        check(done_k - rec_t[exp_n-1] == 2, "R9", "done offset",
              done_k - rec_t[exp_n-1], 2);
      if (v.op == 8'h00)
        check(done_k - rec_t[exp_n-1] == int'(v.d) + 2, "R10", "done after delay",
              done_k - rec_t[exp_n-1], int'(v.d) + 2);
      if (v.op == 8'hFF) begin
        check(rec_t[1] - rec_t[0] == int'(v.d) + wl + 4, "R11", "status spacing",
              rec_t[1] - rec_t[0], int'(v.d) + wl + 4);
        check(ack_k >= 0 && done_k == ack_k + 1, "R11", "done after ack",
              done_k, ack_k + 1);
      end
    end
    @(negedge clk);
    check(!done && !busy, "R12", "done one clock", {done, busy}, 0);
    check(nand_ce_n && nand_we_n && !nand_cle && !nand_ale, "R1", "idle bus",
          {nand_ce_n, nand_we_n, nand_cle, nand_ale}, 4'b1100);
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tests = 0; fails = 0;
    rst_n = 1'b0; start = 1'b0; op_code = '0; col_vld = 1'b0; row_vld = 1'b0;
    col_addr = '0; row_addr = '0; cap_big = 1'b0; bus_wide = 1'b0;
    we_low_clks = 4'd1; wait_clks = '0; poll_ack = 1'b0;
    repeat (4) @(negedge clk);
    check(!busy && nand_ce_n && nand_we_n && !nand_cle && !nand_ale && !done,
          "R1", "reset state", {busy, nand_ce_n, nand_we_n, nand_cle, nand_ale}, 5'b01100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && nand_ce_n && nand_we_n, "R1", "after release",
          {busy, nand_ce_n, nand_we_n}, 3'b011);

    for (int i = 0; i < NVEC; i++) run_vec(VECS[i], 1'b0);

    // R1: start pulses while busy must not change the emitted sequence
    run_vec(VECS[0], 1'b1);

    // R7: no address latches, generic opcode still completes
    run_vec('{8'h10, 1'b0, 16'h5555, 1'b0, 24'h555555, 1'b1, 1'b1, 4'd1, 8'd0}, 1'b0);

    // reset mid-operation returns to idle
    @(negedge clk);
    op_code = 8'h00; col_vld = 1'b1; row_vld = 1'b1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!busy && nand_ce_n && nand_we_n && !nand_cle && !nand_ale, "R1",
          "reset mid-request", {busy, nand_ce_n, nand_we_n}, 3'b011);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule